// File: doc/BRIEF.md
# Single-Wire LED Bit Waveform Encoder

This block turns a stream of data bits into the pulse-width code that daisy-chained smart RGB LEDs read on their single data wire. A free-running period counter divides time into bit cells of fixed length. In every cell that carries a bit, the output goes high as the cell starts. A zero bit drops the output at an early compare point and a one bit drops it at a later compare point. Two pulse registers are set together when the counter restarts, and each is cleared at its own compare value. A selector register, loaded when the short pulse ends, picks which of the two pulses reaches the pin.

Bits arrive on a valid/ready handshake with a flag that marks the first bit of a frame. A bit is taken only at a cell boundary. When no bit is offered there, the cell stays low. Before a new frame may start, the output must have been low for a set number of whole cells after the last bit of the previous frame. This gives the LEDs their latch interval. The default is 21 cells, about 52 us at the target cell length of roughly 2.48 us. The default high times are 10 counts (about 550 ns) for a zero and 22 counts (about 1.18 us) for a one, in a cell of 46 counts.

Top module: `ledwire_encoder`

## Requirements
- R1: The bit cell is CELL_LAST+1 clock cycles long (default 46). When bits are offered back to back, consecutive rising edges of `wire_out` are exactly one cell apart. The rise comes in the cycle right after the accepting clock edge.
- R2: A zero bit (`bit_data` = 0) drives `wire_out` high for exactly T0_CMP cycles (default 10) from the start of its cell.
- R3: A one bit (`bit_data` = 1) drives `wire_out` high for exactly T1_CMP cycles (default 22) from the start of its cell.
- R4: A cell that starts without an accepted bit keeps `wire_out` low for the whole cell, so a one-cell stall makes the next rise come two cells after the previous one.
- R5: `bit_ready` is high only in the last cycle of a cell, so any two of its pulses are a whole number of cells apart.
- R6: A bit with `bit_first` = 1 is accepted only once GAP_CELLS whole idle cells have passed since the last active cell. When a new frame is offered at once, its first rise comes exactly (GAP_CELLS+1) cells after the previous frame's last rise.
- R7: A bit with `bit_first` = 0 is not held back by the latch interval: offered right after a frame, it starts in the very next cell.
- R8: While `rst` is high and in the cycle after it is released, `wire_out` and `bit_ready` are low.
- R9: The first frame after reset needs no latch interval. Its first bit is accepted at the first cell boundary, at most CELL_LAST+2 cycles after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | A bit is offered |
| bit_data | input | 1 | The offered bit value (0 short pulse, 1 long pulse) |
| bit_first | input | 1 | The offered bit opens a new frame |
| bit_ready | output | 1 | The offered bit is taken at this clock edge |
| wire_out | output | 1 | Serial pulse-width coded LED data |

## Verification
Two events can coincide at a cell boundary. One is the ending of the latch interval for a pending first-of-frame bit. The other is the restart of the pulse pair for the cell that follows. The bench offers the next frame immediately after the last bit of the previous one, so the first bit waits at every boundary until the gap runs out. It then measures the rise-to-rise distance, which must be exactly GAP_CELLS+1 cells, and checks the high time of that first cell. A one-cell stall inside a frame and a non-first bit offered right after a frame test the other side of the same boundary decision.

// File: rtl/ledwire_pkg.sv
package ledwire_pkg;

    localparam int DEF_CELL_LAST = 45;
    localparam int DEF_T0_CMP    = 10;
    localparam int DEF_T1_CMP    = 22;
    localparam int DEF_GAP_CELLS = 21;

    // Pair of compare-derived pulses sharing one rising edge
    typedef struct packed {
        logic short_hi;
        logic long_hi;
    } pulse_pair_t;

    // Offered bit with its frame marker
    typedef struct packed {
        logic data;
        logic first;
    } tx_bit_t;

    function automatic bit timing_ok(input int last, input int t0, input int t1);
        return (t0 > 0) && (t0 < t1) && (t1 <= last);
    endfunction

endpackage

// File: rtl/ledwire_cell_timer.sv
module ledwire_cell_timer
    import ledwire_pkg::*;
#(
    parameter int CELL_LAST = DEF_CELL_LAST,
    parameter int T0_CMP    = DEF_T0_CMP,
    parameter int T1_CMP    = DEF_T1_CMP
) (
    input  logic        clk,
    input  logic        rst,
    output logic        cell_wrap,
    output logic        short_end,
    output pulse_pair_t pulses
);

    localparam int CNT_W = (CELL_LAST < 1) ? 1 : $clog2(CELL_LAST + 1);

    logic [CNT_W-1:0] cnt_q;
    pulse_pair_t      pulse_q;
    logic             long_end;

    assign cell_wrap = (cnt_q == CNT_W'(CELL_LAST));
    assign short_end = (cnt_q == CNT_W'(T0_CMP - 1));
    assign long_end  = (cnt_q == CNT_W'(T1_CMP - 1));
    assign pulses    = pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q            <= '0;
            pulse_q.short_hi <= 1'b1;
            pulse_q.long_hi  <= 1'b1;
        end else begin
            if (cell_wrap) begin
                cnt_q            <= '0;
                pulse_q.short_hi <= 1'b1;
                pulse_q.long_hi  <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (short_end) pulse_q.short_hi <= 1'b0;
                if (long_end)  pulse_q.long_hi  <= 1'b0;
            end
        end
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(CELL_LAST));

    // R1
    cell_restart_chk: assert property (@(posedge clk) disable iff (rst)
        cell_wrap |=> (cnt_q == '0) && pulse_q.short_hi && pulse_q.long_hi);

    // R2
    pulse_nest_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q.short_hi |-> pulse_q.long_hi);

    // R3
    long_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_q.long_hi) |-> (cnt_q == CNT_W'(T1_CMP)));

endmodule

// File: rtl/ledwire_gap_guard.sv
module ledwire_gap_guard
    import ledwire_pkg::*;
#(
    parameter int GAP_CELLS = DEF_GAP_CELLS
) (
    input  logic clk,
    input  logic rst,
    input  logic cell_wrap,
    input  logic cell_active,
    output logic gap_done
);

    localparam int GAP_W = (GAP_CELLS < 1) ? 1 : $clog2(GAP_CELLS + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(GAP_CELLS);

    logic [GAP_W-1:0] idle_q;
    logic [GAP_W-1:0] idle_done;

    // Whole idle cells completed once the current cell closes
    always_comb begin
        if (cell_active)          idle_done = '0;
        else if (idle_q == GAP_MAX) idle_done = GAP_MAX;
        else                      idle_done = idle_q + 1'b1;
    end

    assign gap_done = (idle_done == GAP_MAX);

    always_ff @(posedge clk) begin
        if (rst)            idle_q <= GAP_MAX;
        else if (cell_wrap) idle_q <= idle_done;
    end

    // R6
    gap_sat_chk: assert property (@(posedge clk) disable iff (rst)
        idle_q <= GAP_MAX);

    // R6
    gap_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cell_wrap && cell_active) |=> (idle_q == '0));

endmodule

// File: rtl/ledwire_bit_path.sv
module ledwire_bit_path
    import ledwire_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cell_wrap,
    input  logic        short_end,
    input  pulse_pair_t pulses,
    input  logic        take,
    input  tx_bit_t     offered,
    output logic        cell_active,
    output logic        line_out
);

    logic stage_q;
    logic sel_q;
    logic active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            stage_q  <= 1'b0;
            sel_q    <= 1'b0;
        end else begin
            if (cell_wrap) begin
                active_q <= take;
                if (take) stage_q <= offered.data;
            end
            // selector loads as the short pulse ends; both pulses are high before
            if (short_end) sel_q <= stage_q;
        end
    end

    assign cell_active = active_q;
    assign line_out    = active_q & (sel_q ? pulses.long_hi : pulses.short_hi);

    // R4
    rise_needs_take_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(line_out) |-> $past(take && cell_wrap));

    // R2
    sel_load_chk: assert property (@(posedge clk) disable iff (rst)
        short_end |=> (sel_q == $past(stage_q)));

    // R4
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> !line_out);

endmodule

// File: rtl/ledwire_encoder.sv
module ledwire_encoder
    import ledwire_pkg::*;
#(
    parameter int CELL_LAST = DEF_CELL_LAST,
    parameter int T0_CMP    = DEF_T0_CMP,
    parameter int T1_CMP    = DEF_T1_CMP,
    parameter int GAP_CELLS = DEF_GAP_CELLS
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_data,
    input  logic bit_first,
    output logic bit_ready,
    output logic wire_out
);

    logic        cell_wrap;
    logic        short_end;
    pulse_pair_t pulses;
    logic        cell_active;
    logic        gap_done;
    logic        take;
    tx_bit_t     offered;

    initial begin
        timing_cfg_chk: assert (timing_ok(CELL_LAST, T0_CMP, T1_CMP) && GAP_CELLS >= 1);
    end

    assign offered.data  = bit_data;
    assign offered.first = bit_first;

    // A first-of-frame bit waits for the latch interval; others go at any boundary
    assign bit_ready = cell_wrap && (!offered.first || gap_done);
    assign take      = bit_valid && bit_ready;

    ledwire_cell_timer #(
        .CELL_LAST (CELL_LAST),
        .T0_CMP    (T0_CMP),
        .T1_CMP    (T1_CMP)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .cell_wrap (cell_wrap),
        .short_end (short_end),
        .pulses    (pulses)
    );

    ledwire_gap_guard #(
        .GAP_CELLS (GAP_CELLS)
    ) u_gap (
        .clk         (clk),
        .rst         (rst),
        .cell_wrap   (cell_wrap),
        .cell_active (cell_active),
        .gap_done    (gap_done)
    );

    ledwire_bit_path u_path (
        .clk         (clk),
        .rst         (rst),
        .cell_wrap   (cell_wrap),
        .short_end   (short_end),
        .pulses      (pulses),
        .take        (take),
        .offered     (offered),
        .cell_active (cell_active),
        .line_out    (wire_out)
    );

    // R5
    ready_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        bit_ready |=> !bit_ready);

    // R6
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cell_wrap && cell_active && bit_first) |-> !bit_ready);

endmodule

// File: tb/sim_ledwire_encoder.sv
module sim_ledwire_encoder;

    localparam int LAST = 45;
    localparam int CELL = LAST + 1;
    localparam int T0   = 10;
    localparam int T1   = 22;
    localparam int GAP  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit   = 1'b0;
    logic in_first = 1'b0;
    logic ready;
    logic dout;

    always #5 clk = ~clk;

    ledwire_encoder #(
        .CELL_LAST (LAST),
        .T0_CMP    (T0),
        .T1_CMP    (T1),
        .GAP_CELLS (GAP)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (in_valid),
        .bit_data  (in_bit),
        .bit_first (in_first),
        .bit_ready (ready),
        .wire_out  (dout)
    );

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: acceptance, rise timing and high time of every cell
    bit exp_q[$];
    int acc_q[$];
    int rise_q[$];
    logic prev_d = 1'b0;
    int   rise_t = 0;
    bit   cur_b  = 1'b0;
    int   last_ready = -1;

    always @(negedge clk) begin
        if (!rst) begin
            if (ready) begin
                if (last_ready >= 0)
                    chk(((cyc - last_ready) % CELL) == 0, "R5 ready spacing", cyc - last_ready, CELL);
                last_ready = cyc;
            end
            if (in_valid && ready) begin
                exp_q.push_back(in_bit);
                acc_q.push_back(cyc);
            end
            if (dout && !prev_d) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 rise without accepted bit", 1, 0);
                end else begin
                    int a;
                    cur_b = exp_q.pop_front();
                    a = acc_q.pop_front();
                    chk(cyc == a + 1, "R1 rise after acceptance", cyc, a + 1);
                    rise_t = cyc;
                    rise_q.push_back(cyc);
                end
            end
            if (!dout && prev_d) begin
                if (cur_b) chk(cyc - rise_t == T1, "R3 one high time", cyc - rise_t, T1);
                else       chk(cyc - rise_t == T0, "R2 zero high time", cyc - rise_t, T0);
            end
            prev_d = dout;
        end
    end

    // Offer one bit and hold it until taken
    task automatic send(input bit b, input bit f);
        in_valid = 1'b1;
        in_bit   = b;
        in_first = f;
        do @(negedge clk); while (!ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (CELL + 4) @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    int rel;
    int base;

    initial begin
        // R8 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dout == 1'b0, "R8 output low in reset", dout, 0);
        chk(ready == 1'b0, "R8 ready low in reset", ready, 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        rel = cyc;
        @(negedge clk);
        chk(dout == 1'b0, "R8 output low after release", dout, 0);
        chk(ready == 1'b0, "R8 ready low after release", ready, 0);
        @(posedge clk);
        #1;

        // Frame 1: 10110010, no latch wait after reset
        base = rise_q.size();
        for (int i = 7; i >= 0; i--) send(((8'b1011_0010 >> i) & 1) != 0, i == 7);
        settle();
        chk(rise_q.size() == base + 8, "R1 frame one cell count", rise_q.size() - base, 8);
        if (rise_q.size() == base + 8) begin
            chk(rise_q[base] - rel <= LAST + 2, "R9 first frame immediate", rise_q[base] - rel, LAST + 2);
            for (int i = 1; i < 8; i++)
                chk(rise_q[base + i] - rise_q[base + i - 1] == CELL, "R1 back-to-back period",
                    rise_q[base + i] - rise_q[base + i - 1], CELL);
        end

        // Frame 2 offered at once: waits the latch gap
        base = rise_q.size();
        send(1'b1, 1'b1);
        send(1'b0, 1'b0);
        send(1'b0, 1'b0);
        send(1'b1, 1'b0);
        // R7: non-first bit right after the frame
        send(1'b0, 1'b0);
        // R4: one-cell stall inside the frame
        repeat (CELL) @(posedge clk);
        #1;
        send(1'b1, 1'b0);
        settle();
        chk(rise_q.size() == base + 6, "R6 frame two cell count", rise_q.size() - base, 6);
        if (rise_q.size() == base + 6) begin
            chk(rise_q[base] - rise_q[base - 1] == (GAP + 1) * CELL, "R6 latch gap before new frame",
                rise_q[base] - rise_q[base - 1], (GAP + 1) * CELL);
            chk(rise_q[base + 4] - rise_q[base + 3] == CELL, "R7 non-first bit not delayed",
                rise_q[base + 4] - rise_q[base + 3], CELL);
            chk(rise_q[base + 5] - rise_q[base + 4] == 2 * CELL, "R4 stalled cell stays low",
                rise_q[base + 5] - rise_q[base + 4], 2 * CELL);
        end

        // Sweep every 4-bit pattern as its own frame, each offered at once
        for (int p = 0; p < 16; p++) begin
            base = rise_q.size();
            for (int i = 3; i >= 0; i--) send(((p >> i) & 1) != 0, i == 3);
            settle();
            chk(rise_q.size() == base + 4, "R1 sweep cell count", rise_q.size() - base, 4);
            if (rise_q.size() == base + 4) begin
                chk(rise_q[base] - rise_q[base - 1] == (GAP + 1) * CELL, "R6 sweep latch gap",
                    rise_q[base] - rise_q[base - 1], (GAP + 1) * CELL);
                chk(rise_q[base + 3] - rise_q[base] == 3 * CELL, "R1 sweep period",
                    rise_q[base + 3] - rise_q[base], 3 * CELL);
            end
        end

        repeat (CELL * 2) @(posedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R4 every accepted bit emitted", exp_q.size(), 0);
        chk(dout == 1'b0, "R4 output low when idle", dout, 0);
        finish_run();
    end

endmodule